// File: doc/BRIEF.md
# In-Flight Quad Conflict Tracker

This block sits in front of shader dispatch for pixel shaders that read the render target at their own location. It remembers every quad that is still being shaded and refuses to issue a new quad that would write a sample one of those quads is about to write. This keeps read-modify-write order at each sample without serializing work that does not actually overlap.

Each table entry holds a busy flag, the quad's screen position and a coverage mask with one bit per sample. The mask is 16 bits wide: 4 pixels times 4 samples. An arriving quad is compared with all entries in parallel. A collision needs both an exact position match and a non-zero AND of the two masks. A quad that does not collide is written into the lowest free entry, and the entry number goes out as its slot ID. When shading finishes, the completion port names that slot ID, and the entry is released.

The dispatch side uses a valid/ready handshake. `req_ready` is a function of the request fields and of the registered table only. It never depends on `req_valid`. While `req_ready` is low, the requester holds `req_valid` and the fields stable, and the quad is taken in the first cycle where both are high. The completion port is plain control with no back-pressure. A completion is always taken.

Top module: `quad_conflict_tracker`

## Requirements
- R1: After reset every entry is free. A request of any position and coverage is accepted, and `issue_slot` is 0.
- R2: A request whose position equals that of a busy entry and whose coverage ANDs non-zero with that entry's coverage holds `req_ready` low.
- R3: A request at the same position as a busy entry with a disjoint coverage mask is accepted. Tracking is per sample, not per pixel.
- R4: A request with overlapping coverage but a different position (X or Y differs) is accepted.
- R5: When all entries are busy, `req_ready` is low even without a collision.
- R6: When `req_ready` is high, `issue_slot` names the lowest-numbered free entry, and an accepted quad occupies that entry.
- R7: An accepted quad is busy from the next cycle. An identical request one cycle later stalls.
- R8: A completion releases its entry at the clock edge. A request blocked by that entry is still stalled in the completion cycle and is accepted the cycle after.
- R9: A completion and an acceptance in the same cycle both take effect. The accepted quad takes a slot that was free before the edge, and the completed slot is free afterwards.
- R10: A completion that names a free slot changes nothing. The next acceptance and all stalls are as if the completion had not been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Dispatch request present |
| req_ready | output | 1 | Request can be taken this cycle (grant); low means stall |
| req_x | input | 11 | Quad X position |
| req_y | input | 11 | Quad Y position |
| req_cov | input | 16 | Sample coverage; bit 4*p+s is sample s of pixel p |
| issue_slot | output | 4 | Slot ID given to the quad; meaningful while `req_ready` is high |
| done_valid | input | 1 | Completion strobe |
| done_slot | input | 4 | Slot ID of the completed quad |

## Verification
The dispatch decision (`req_ready`, `issue_slot`) is combinational on the registered table. It is due in the same cycle as the request. The bench drives each cycle's inputs just after the falling edge and compares those outputs a moment later, before the rising edge. A table change, whether an insertion or a release, becomes visible only one rising edge later. The bench's own table model is therefore updated at that edge and used for the next cycle's expectation. This matches the one-cycle delay named in R7 and R8.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int unsigned QT_ENTRIES = 16;
  localparam int unsigned QT_XW      = 11;
  localparam int unsigned QT_YW      = 11;
  localparam int unsigned QT_PIX     = 4;
  localparam int unsigned QT_SAMP    = 4;

  typedef enum logic [1:0] {
    QT_ISSUE = 2'd0,
    QT_HIT   = 2'd1,
    QT_FULL  = 2'd2,
    QT_IDLE  = 2'd3
  } qt_verdict_e;
endpackage

// File: rtl/qt_entry.sv
module qt_entry #(
  parameter int unsigned XW  = 11,
  parameter int unsigned YW  = 11,
  parameter int unsigned CW  = 16,
  parameter int unsigned SW  = 4,
  parameter int unsigned IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          rel_valid,
  input  logic [SW-1:0] rel_slot,
  input  logic [XW-1:0] cmp_x,
  input  logic [YW-1:0] cmp_y,
  input  logic [CW-1:0] cmp_cov,
  output logic          busy,
  output logic          hit
);
  logic [XW-1:0] pos_x;
  logic [YW-1:0] pos_y;
  logic [CW-1:0] cov;
  logic          rel_me;

  assign rel_me = rel_valid && (rel_slot == SW'(IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pos_x <= '0;
      pos_y <= '0;
      cov   <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      pos_x <= cmp_x;
      pos_y <= cmp_y;
      cov   <= cmp_cov;
    end else if (rel_me) begin
      busy  <= 1'b0;
    end
  end

  always_comb begin
    hit = busy && (pos_x == cmp_x) && (pos_y == cmp_y) && (|(cov & cmp_cov));
  end

  AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy) // R6
    else $error("entry loaded while busy");
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_me && !load) |=> !busy) // R8
    else $error("entry still busy after release");
endmodule

// File: rtl/qt_pick_free.sv
module qt_pick_free #(
  parameter int unsigned N  = 16,
  parameter int unsigned SW = 4
) (
  input  logic [N-1:0]  busy,
  output logic          any_free,
  output logic [SW-1:0] first
);
  always_comb begin
    any_free = 1'b0;
    first    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        first    = SW'(i);
      end
    end
  end
endmodule

// File: rtl/quad_conflict_tracker.sv
module quad_conflict_tracker
  import qt_pkg::*;
#(
  parameter int unsigned ENTRIES = QT_ENTRIES,
  parameter int unsigned XW      = QT_XW,
  parameter int unsigned YW      = QT_YW,
  parameter int unsigned PIX     = QT_PIX,
  parameter int unsigned SAMP    = QT_SAMP,
  localparam int unsigned CW     = PIX * SAMP,
  localparam int unsigned SW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [XW-1:0] req_x,
  input  logic [YW-1:0] req_y,
  input  logic [CW-1:0] req_cov,
  output logic [SW-1:0] issue_slot,
  input  logic          done_valid,
  input  logic [SW-1:0] done_slot
);
  logic [ENTRIES-1:0] busy;
  logic [ENTRIES-1:0] hit;
  logic [ENTRIES-1:0] load;
  logic               any_free;
  logic [SW-1:0]      free_idx;
  logic               take;
  qt_verdict_e        verdict;

  qt_pick_free #(.N(ENTRIES), .SW(SW)) u_pick (
    .busy     (busy),
    .any_free (any_free),
    .first    (free_idx)
  );

  always_comb begin
    if (|hit)            verdict = QT_HIT;
    else if (!any_free)  verdict = QT_FULL;
    else if (!req_valid) verdict = QT_IDLE;
    else                 verdict = QT_ISSUE;
  end

  assign req_ready  = !(|hit) && any_free;
  assign issue_slot = free_idx;
  assign take       = (verdict == QT_ISSUE);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign load[g] = take && (free_idx == SW'(g));
    qt_entry #(.XW(XW), .YW(YW), .CW(CW), .SW(SW), .IDX(g)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load[g]),
      .rel_valid (done_valid),
      .rel_slot  (done_slot),
      .cmp_x     (req_x),
      .cmp_y     (req_y),
      .cmp_cov   (req_cov),
      .busy      (busy[g]),
      .hit       (hit[g])
    );
  end

  AST_HIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |-> !req_ready) // R2
    else $error("grant despite collision");
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !req_ready) // R5
    else $error("grant while table full");
  AST_GRANT_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !busy[issue_slot]) // R6
    else $error("granted slot already busy");
  AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy[$past(issue_slot)]) // R7
    else $error("granted slot not busy next cycle");
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load)) // R6
    else $error("more than one entry loaded");
endmodule

// File: tb/sim_quad_conflict_tracker.sv
module sim_quad_conflict_tracker;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [10:0] req_x = '0;
  logic [10:0] req_y = '0;
  logic [15:0] req_cov = '0;
  logic [3:0]  issue_slot;
  logic        done_valid = 1'b0;
  logic [3:0]  done_slot = '0;

  int tests = 0;
  int fails = 0;

  logic        mv [N];
  logic [10:0] mx [N];
  logic [10:0] my [N];
  logic [15:0] mc [N];

  always #10 clk = ~clk;

  quad_conflict_tracker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .req_cov(req_cov), .issue_slot(issue_slot),
    .done_valid(done_valid), .done_slot(done_slot)
  );

  function automatic logic exp_ready(logic [10:0] x, logic [10:0] y, logic [15:0] c);
    logic free_seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (mv[i] && mx[i] == x && my[i] == y && (c & mc[i]) != 0) return 1'b0;
      if (!mv[i]) free_seen = 1'b1;
    end
    return free_seen;
  endfunction

  function automatic logic [3:0] exp_slot();
    for (int i = 0; i < N; i++) if (!mv[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic step(input logic v, input logic [10:0] x, input logic [10:0] y,
                      input logic [15:0] c, input logic dv, input logic [3:0] ds,
                      input string tag);
    logic er;
    logic [3:0] es;
    req_valid = v; req_x = x; req_y = y; req_cov = c;
    done_valid = dv; done_slot = ds;
    #1;
    er = exp_ready(x, y, c);
    es = exp_slot();
    tests++;
    if (req_ready !== er) begin
      fails++;
      $display("FAIL %s ready actual=%0b expected=%0b", tag, req_ready, er);
    end
    if (v && er) begin
      tests++;
      if (issue_slot !== es) begin
        fails++;
        $display("FAIL %s slot actual=%0d expected=%0d", tag, issue_slot, es);
      end
    end
    @(posedge clk);
    if (dv && mv[ds]) mv[ds] = 1'b0;
    if (v && er) begin
      mv[es] = 1'b1; mx[es] = x; my[es] = y; mc[es] = c;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) begin mv[i] = 0; mx[i] = 0; my[i] = 0; mc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 0, 0, 16'h000F, 0, 0, "R1");
    step(1, 0, 0, 16'h00F0, 0, 0, "R3");
    step(1, 0, 0, 16'h0001, 0, 0, "R2");
    step(1, 0, 0, 16'h00F0, 0, 0, "R7");
    step(1, 1, 0, 16'h000F, 0, 0, "R4");
    step(1, 0, 1, 16'h00F0, 0, 0, "R4");
    step(1, 0, 0, 16'h0001, 1, 0, "R8");
    step(1, 0, 0, 16'h0001, 0, 0, "R8");
    for (int k = 0; k < 12; k++) step(1, 11'(k), 11'd9, 16'hFFFF, 0, 0, "R6");
    step(1, 11'd100, 11'd100, 16'h8000, 0, 0, "R5");
    step(1, 11'd100, 11'd100, 16'h8000, 1, 4'd3, "R5");
    step(1, 11'd101, 11'd100, 16'h8000, 1, 4'd7, "R9");
    step(1, 11'd102, 11'd100, 16'h8000, 0, 0, "R9");
    step(0, 0, 0, 16'h0000, 1, 4'd7, "R10");
    step(0, 0, 0, 16'h0000, 1, 4'd7, "R10");
    step(1, 0, 0, 16'h0001, 0, 0, "R10");
    for (int s = 0; s < N; s++) step(0, 0, 0, 0, 1, 4'(s), "R8");
    step(1, 5, 5, 16'h0F00, 0, 0, "R1");

    for (int n = 0; n < 4000; n++) begin
      logic v, dv;
      logic [15:0] c;
      v  = ($urandom % 4) != 0;
      dv = ($urandom % 3) == 0;
      c  = 16'($urandom) & 16'($urandom) & 16'($urandom);
      step(v, 11'($urandom % 2), 11'($urandom % 2), c, dv, 4'($urandom % N), "R2/R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule